// File: doc/BRIEF.md
# Single-Precision Multiply Normalize-and-Round Stage

This block finishes a single-precision floating-point multiply once the 24-bit by 24-bit significand product has been formed upstream. It takes the two operand sign bits, the two biased 8-bit exponent fields and the 48-bit unsigned significand product. From these it forms the packed 32-bit result: sign, exponent and 23-bit fraction.

The result sign is the XOR of the operand signs and is computed apart from the other paths. The exponents are summed and the bias is removed once. The product is then normalized on its top bit. Guard, round and sticky bits are taken from the bits below the kept significand, and round-to-nearest-even is applied. A carry out of rounding feeds back into the exponent.

Special values are handled in a reduced way. A zero exponent field on either operand yields signed zero. A final exponent too large saturates to signed infinity and sets the overflow flag. A final exponent too small flushes to signed zero and sets the underflow flag. The result and flags are registered, so they appear one clock after the inputs are presented.

Top module: `fmul_norm_round`

## Requirements
- R1: Bit 31 of the result equals sign_a_i XOR sign_b_i for every input, including zero, infinity and flushed results.
- R2: When both exponent fields are nonzero, product bit 47 is 0 and bit 46 is 1, and no rounding carry occurs, the result exponent field is exp_a_i + exp_b_i - 127. The fraction is product bits 45:23, plus one ulp when rounding increments.
- R3: When product bit 47 is 1, the significand is taken from bits 47:24 (fraction 46:24), the guard bit is bit 23, and the exponent is one higher than in R2.
- R4: Rounding increments the fraction when the discarded part is above half an ulp (guard 1 with round or sticky set). It leaves the fraction unchanged when the guard bit is 0. Sticky is the OR of every product bit below the round bit after normalization.
- R5: On an exact tie (guard 1, round 0, sticky 0), the fraction is incremented only if its LSB is 1, so the result is always even.
- R6: A rounding increment of an all-ones fraction gives a fraction of 0 and adds one more to the exponent.
- R7: A final exponent of 255 or more gives exponent field 0xFF, fraction 0, overflow_o = 1 and underflow_o = 0.
- R8: A final exponent of 0 or less, with both operands nonzero, gives exponent and fraction 0, underflow_o = 1 and overflow_o = 0.
- R9: If either exponent field is 0, the result is signed zero with both flags 0, whatever prod_i holds.
- R10: While rst_ni is low, result_o, overflow_o and underflow_o are 0. Otherwise each output reflects the inputs sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sign_a_i | input | 1 | Sign of operand A |
| sign_b_i | input | 1 | Sign of operand B |
| exp_a_i | input | 8 | Biased exponent field of operand A |
| exp_b_i | input | 8 | Biased exponent field of operand B |
| prod_i | input | 48 | Unsigned product of the two 24-bit significands |
| result_o | output | 32 | Packed single-precision result |
| overflow_o | output | 1 | Result saturated to infinity |
| underflow_o | output | 1 | Result flushed to zero |

## Verification
The sweeps cross significand patterns near 1.0, near 2.0 and in between with exponent fields that sit on both sides of the overflow and underflow thresholds. Directed vectors probe the ties, the all-ones fraction that carries into the exponent, and a carry that pushes exponent 254 into overflow. A design that rounded ties away from zero would come out odd on the even-tie vector. A design that dropped the rounding carry would report an exponent one low with a zero fraction. A design that forgot the bit-47 shift would be off by one in the exponent and misplace the guard bit. A design that took sticky from the wrong bit range would round the above-half vectors down.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
  localparam int unsigned EXP_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 23;

  typedef struct packed {
    logic guard;
    logic round;
    logic sticky;
  } grs_t;
endpackage

// File: rtl/fmr_sign_exp.sv
module fmr_sign_exp #(
  parameter int unsigned EXP_W = 8,
  localparam int unsigned ESW  = EXP_W + 2
) (
  input  logic                  sign_a_i,
  input  logic                  sign_b_i,
  input  logic [EXP_W-1:0]      exp_a_i,
  input  logic [EXP_W-1:0]      exp_b_i,
  output logic                  sign_o,
  output logic                  zero_op_o,
  output logic signed [ESW-1:0] exp_sum_o
);
  localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [ESW-1:0] BIAS_S = ESW'(BIAS);

  assign sign_o    = sign_a_i ^ sign_b_i;
  assign zero_op_o = ~|exp_a_i | ~|exp_b_i;
  assign exp_sum_o = $signed({2'b00, exp_a_i}) + $signed({2'b00, exp_b_i}) - BIAS_S;
endmodule

// File: rtl/fmr_normalize.sv
module fmr_normalize
  import fmr_pkg::*;
#(
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W
) (
  input  logic [PROD_W-1:0] prod_i,
  output logic              hi_o,
  output logic [FRAC_W-1:0] frac_o,
  output grs_t              grs_o
);
  // leading one sits at bit PROD_W-1 or PROD_W-2; drop it after alignment
  logic [PROD_W-2:0] norm;

  assign hi_o = prod_i[PROD_W-1];
  assign norm = hi_o ? prod_i[PROD_W-2:0] : {prod_i[PROD_W-3:0], 1'b0};

  assign frac_o       = norm[PROD_W-2 -: FRAC_W];
  assign grs_o.guard  = norm[PROD_W-2-FRAC_W];
  assign grs_o.round  = norm[PROD_W-3-FRAC_W];
  assign grs_o.sticky = |norm[PROD_W-4-FRAC_W:0];
endmodule

// File: rtl/fmr_round.sv
module fmr_round
  import fmr_pkg::*;
#(
  parameter int unsigned FRAC_W = 23
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  grs_t              grs_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              carry_o
);
  logic          inc;
  logic [FRAC_W:0] sum;

  // nearest-even: above half, or exact half with odd lsb
  assign inc     = grs_i.guard & (grs_i.round | grs_i.sticky | frac_i[0]);
  assign sum     = {1'b0, frac_i} + {{FRAC_W{1'b0}}, inc};
  assign carry_o = sum[FRAC_W];
  assign frac_o  = sum[FRAC_W-1:0];  // zero on carry: 1.111..1 + ulp = 10.000..0
endmodule

// File: rtl/fmul_norm_round.sv
module fmul_norm_round
  import fmr_pkg::*;
#(
  parameter int unsigned EXP_W  = EXP_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sign_a_i,
  input  logic              sign_b_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [W-1:0]      result_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int unsigned ESW = EXP_W + 2;
  localparam logic signed [ESW-1:0] EXP_MAX_S = ESW'((1 << EXP_W) - 1);
  localparam logic signed [ESW-1:0] ZERO_S    = '0;

  logic                  sign;
  logic                  zero_op;
  logic signed [ESW-1:0] exp_sum;
  logic                  hi;
  logic [FRAC_W-1:0]     frac_n;
  grs_t                  grs;
  logic [FRAC_W-1:0]     frac_r;
  logic                  carry;
  logic signed [ESW-1:0] exp_fin;

  logic [W-1:0] result_d;
  logic         ovf_d, unf_d;

  fmr_sign_exp #(.EXP_W(EXP_W)) u_sign_exp (
    .sign_a_i (sign_a_i),
    .sign_b_i (sign_b_i),
    .exp_a_i  (exp_a_i),
    .exp_b_i  (exp_b_i),
    .sign_o   (sign),
    .zero_op_o(zero_op),
    .exp_sum_o(exp_sum)
  );

  fmr_normalize #(.FRAC_W(FRAC_W)) u_norm (
    .prod_i(prod_i),
    .hi_o  (hi),
    .frac_o(frac_n),
    .grs_o (grs)
  );

  fmr_round #(.FRAC_W(FRAC_W)) u_round (
    .frac_i (frac_n),
    .grs_i  (grs),
    .frac_o (frac_r),
    .carry_o(carry)
  );

  // both normalization shift and rounding carry bump the exponent
  assign exp_fin = exp_sum
                 + $signed({{(ESW-1){1'b0}}, hi})
                 + $signed({{(ESW-1){1'b0}}, carry});

  always_comb begin
    ovf_d    = 1'b0;
    unf_d    = 1'b0;
    result_d = {sign, exp_fin[EXP_W-1:0], frac_r};
    if (zero_op) begin
      result_d = {sign, {(W-1){1'b0}}};
    end else if (exp_fin >= EXP_MAX_S) begin
      result_d = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_d    = 1'b1;
    end else if (exp_fin <= ZERO_S) begin
      result_d = {sign, {(W-1){1'b0}}};
      unf_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      result_o    <= result_d;
      overflow_o  <= ovf_d;
      underflow_o <= unf_d;
    end
  end
endmodule

// File: rtl/fmul_norm_round_chk.sv
module fmul_norm_round_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned PROD_W = 2 * (FRAC_W + 1),
  localparam int unsigned W      = 1 + EXP_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sign_a_i,
  input logic              sign_b_i,
  input logic [EXP_W-1:0]  exp_a_i,
  input logic [EXP_W-1:0]  exp_b_i,
  input logic [PROD_W-1:0] prod_i,
  input logic [W-1:0]      result_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  logic past_ok;
  logic prod_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign prod_seen = |prod_i;

  // R1
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> result_o[W-1] == $past(sign_a_i ^ sign_b_i));

  // R9
  zero_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(exp_a_i == '0 || exp_b_i == '0)
      |-> result_o[W-2:0] == '0 && !overflow_o && !underflow_o);

  // R7
  overflow_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> result_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && !underflow_o);

  // R8
  underflow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> result_o[W-2:0] == '0 && !overflow_o);

  // R2
  normal_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(exp_a_i != '0 && exp_b_i != '0 && prod_seen) && !overflow_o && !underflow_o
      |-> result_o[W-2 -: EXP_W] != '0 && result_o[W-2 -: EXP_W] != {EXP_W{1'b1}});

  // R10
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> result_o == '0 && !overflow_o && !underflow_o);
endmodule

bind fmul_norm_round fmul_norm_round_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sign_a_i   (sign_a_i),
  .sign_b_i   (sign_b_i),
  .exp_a_i    (exp_a_i),
  .exp_b_i    (exp_b_i),
  .prod_i     (prod_i),
  .result_o   (result_o),
  .overflow_o (overflow_o),
  .underflow_o(underflow_o)
);

// File: tb/fmul_norm_round_test.sv
module fmul_norm_round_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sign_a_i, sign_b_i;
  logic [7:0]  exp_a_i, exp_b_i;
  logic [47:0] prod_i;
  logic [31:0] result_o;
  logic        overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fmul_norm_round uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sign_a_i(sign_a_i), .sign_b_i(sign_b_i),
    .exp_a_i(exp_a_i), .exp_b_i(exp_b_i), .prod_i(prod_i),
    .result_o(result_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic model(input logic sa, input logic sb, input logic [7:0] ea, input logic [7:0] eb,
                       input logic [47:0] p, output logic [31:0] r, output logic ov,
                       output logic un, output logic cy);
    int e;
    int sh;
    logic [63:0] keep, rem, half;
    logic s;
    s = sa ^ sb; ov = 1'b0; un = 1'b0; cy = 1'b0;
    if (ea == 8'd0 || eb == 8'd0) begin
      r = {s, 31'b0};
      return;
    end
    e  = int'(ea) + int'(eb) - 127;
    sh = p[47] ? 24 : 23;
    if (p[47]) e++;
    keep = {16'b0, p} >> sh;
    rem  = {16'b0, p} & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep++;
    if (keep == (64'd1 << 24)) begin
      keep = keep >> 1; e++; cy = 1'b1;
    end
    if (e >= 255) begin
      r = {s, 8'hFF, 23'b0}; ov = 1'b1;
    end else if (e <= 0) begin
      r = {s, 31'b0}; un = 1'b1;
    end else begin
      r = {s, e[7:0], keep[22:0]};
    end
  endtask

  // drive at negedge, compare at the following negedge (one register stage)
  task automatic run(input string tag, input logic sa, input logic sb,
                     input logic [7:0] ea, input logic [7:0] eb, input logic [47:0] p);
    logic [31:0] er;
    logic eo, eu, ec;
    string t;
    @(negedge clk_i);
    sign_a_i = sa; sign_b_i = sb; exp_a_i = ea; exp_b_i = eb; prod_i = p;
    model(sa, sb, ea, eb, p, er, eo, eu, ec);
    t = tag;
    if (t == "") begin
      if (ea == 0 || eb == 0) t = "R9";
      else if (eo)            t = "R7";
      else if (eu)            t = "R8";
      else if (ec)            t = "R6";
      else if (p[47])         t = "R3";
      else                    t = "R2";
    end
    @(negedge clk_i);
    checks++;
    if (result_o[31] !== er[31]) begin
      errors++;
      $display("FAIL R1 sign: got %0b exp %0b", result_o[31], er[31]);
    end
    checks++;
    if (result_o[30:0] !== er[30:0] || overflow_o !== eo || underflow_o !== eu) begin
      errors++;
      $display("FAIL %s ea=%0d eb=%0d p=%h: got %h ov=%0b un=%0b exp %h ov=%0b un=%0b",
               t, ea, eb, p, result_o, overflow_o, underflow_o, er, eo, eu);
    end
  endtask

  initial begin
    logic [23:0] mants [12];
    logic [7:0]  exps  [11];
    mants = '{24'h800000, 24'hFFFFFF, 24'hC00000, 24'hAAAAAB, 24'h800001, 24'hFFFFFE,
              24'hB504F3, 24'h9E3779, 24'hD55555, 24'hF00001, 24'h812345, 24'hE6E6E6};
    exps  = '{8'd0, 8'd1, 8'd2, 8'd63, 8'd64, 8'd65, 8'd127, 8'd128, 8'd191, 8'd192, 8'd254};

    rst_ni = 1'b0;
    sign_a_i = 1'b1; sign_b_i = 1'b0; exp_a_i = 8'd130; exp_b_i = 8'd130;
    prod_i = 48'h8000_0000_0000;
    repeat (3) @(negedge clk_i);
    checks++;
    if (result_o !== 32'b0 || overflow_o !== 1'b0 || underflow_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: got %h %0b %0b exp 0 0 0", result_o, overflow_o, underflow_o);
    end
    rst_ni = 1'b1;

    // R10 latency: output holds until the next rising edge
    @(negedge clk_i);
    sign_a_i = 1'b0; sign_b_i = 1'b0; exp_a_i = 8'd127; exp_b_i = 8'd127;
    prod_i = 48'h4000_0000_0000;
    @(negedge clk_i);
    exp_a_i = 8'd128;
    #1;
    checks++;
    if (result_o !== 32'h3F80_0000) begin
      errors++;
      $display("FAIL R10 latency: got %h exp %h", result_o, 32'h3F80_0000);
    end
    @(negedge clk_i);
    checks++;
    if (result_o !== 32'h4000_0000) begin
      errors++;
      $display("FAIL R10 update: got %h exp %h", result_o, 32'h4000_0000);
    end

    // R4 / R5 directed rounding
    run("R5", 0, 0, 8'd127, 8'd127, (48'h800000 << 23) | (48'h1 << 22));  // tie, even: hold
    run("R5", 1, 0, 8'd127, 8'd127, (48'h800001 << 23) | (48'h1 << 22));  // tie, odd: up
    run("R5", 0, 1, 8'd127, 8'd127, (48'h800001 << 24) | (48'h1 << 23));  // tie after shift
    run("R4", 0, 0, 8'd127, 8'd127, (48'h800000 << 23) | (48'h1 << 22) | 48'h1); // sticky up
    run("R4", 0, 0, 8'd127, 8'd127, (48'h800000 << 23) | (48'h1 << 21) | 48'h1); // guard 0
    run("R4", 1, 1, 8'd100, 8'd140, (48'h800002 << 23) | (48'h3 << 21));  // guard+round
    run("R4", 0, 0, 8'd127, 8'd127, (48'h800000 << 24) | 48'h1);          // sticky only: hold
    run("R6", 0, 0, 8'd127, 8'd127, (48'hFFFFFF << 23) | (48'h1 << 22));  // carry
    run("R6", 1, 0, 8'd127, 8'd127, (48'hFFFFFF << 24) | (48'h1 << 23));  // carry after shift
    run("R7", 0, 0, 8'd127, 8'd254, (48'hFFFFFF << 23) | (48'h1 << 22));  // carry to 255
    run("R7", 1, 0, 8'd127, 8'd254, (48'hFFFFFF << 23));                  // stays 254
    run("R7", 0, 1, 8'd255, 8'd255, 48'h4000_0000_0000);
    run("R8", 1, 0, 8'd63, 8'd64, 48'h4000_0000_0000);                    // exp 0
    run("R8", 0, 0, 8'd63, 8'd64, 48'h8000_0000_0000);                    // shift lifts to 1
    run("R8", 0, 1, 8'd1, 8'd1, 48'hFFFF_FFFF_FFFF);
    run("R9", 1, 0, 8'd0, 8'd200, 48'hFFFF_FFFF_FFFF);
    run("R9", 0, 1, 8'd254, 8'd0, 48'hFFFF_FFFF_FFFF);

    // sweep: real products over exponent pairs around the thresholds
    for (int ia = 0; ia < 11; ia++)
      for (int ib = 0; ib < 11; ib++)
        for (int ma = 0; ma < 12; ma++)
          for (int mb = 0; mb < 12; mb++)
            run("", ma[0], mb[1] ^ ia[0], exps[ia], exps[ib],
                {24'b0, mants[ma]} * {24'b0, mants[mb]});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule